// File: doc/BRIEF.md
# Sticky-Enable Watchdog Timer

A watchdog counter for a microcontroller-style peripheral set. Software controls it through one register write port. The write data carries two things: a kick bit and a two-bit timeout selector. The first write with the kick bit set arms the watchdog. Every later such write restarts the count from zero. Once the watchdog is armed, software has no way to turn it off. Only a hardware reset, or the watchdog's own expiry, returns it to the disarmed state.

A prescaler makes a clock-enable tick, and the counter advances on that tick. The prescaler restarts on every kick, so the time from a kick to expiry is an exact number of clocks. On expiry the block drives an active-low, open-drain style reset request for a fixed number of clocks, which resets the rest of the system. It then comes back disarmed.

The block also samples the external reset line through a length filter. This filter accepts a hardware reset only after the line has been low for enough consecutive clocks. More clocks are required when the stop-mode input is high. An accepted hardware reset disarms the watchdog and clears its count.

Top module: `wdt_sticky`

## Requirements
- R1: A write with wr_data_i[0]=1 to a disarmed watchdog arms it. rst_req_no then goes low exactly T clocks after the write edge, where T is the timeout chosen by wr_data_i[2:1] of that write.
- R2: A write with wr_data_i[0]=1 to an armed watchdog restarts the count. Expiry then comes T clocks after the latest such write, not after the first.
- R3: A write with wr_data_i[0]=0 does not arm the watchdog, disarm it or restart it.
- R4: The selector values 0, 1, 2 and 3 give timeouts of 2^B, 2^(B+2), 2^(B+4) and 2^(B+6) clocks, where B is BASE_LOG2 (default 12).
- R5: A selector written with wr_data_i[0]=0 does not change the running timeout. The selector of a kick write applies from that kick onward.
- R6: On expiry, rst_req_no is low for exactly PULSE_LEN (default 16) consecutive clocks. Writes made while it is low are ignored.
- R7: After the reset pulse the watchdog is disarmed. No further pulse occurs until a new kick write.
- R8: sys_rst_no goes low after MIN_NORM (5) consecutive low samples of ext_rst_ni when stop_mode_i=0, and after MIN_STOP (10) when stop_mode_i=1. One sample fewer leaves it high. It returns high on the first high sample.
- R9: An accepted hardware reset (sys_rst_no low) disarms the watchdog, so no expiry follows.
- R10: After rst_ni, rst_req_no and sys_rst_no are both high and the watchdog is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data: bit 0 kick, bits 2:1 timeout select |
| ext_rst_ni | input | 1 | External reset line sample, active low |
| stop_mode_i | input | 1 | High while the system is in stop mode |
| rst_req_no | output | 1 | Watchdog reset request, active low |
| sys_rst_no | output | 1 | Filtered hardware reset, active low |

## Verification
The bench measures the distance from a kick write to the falling edge of rst_req_no to the exact clock, for each selector value. A design that restarts the prescaler wrongly, or compares the count off by one, is seen as early or late. It kicks in the middle of a timeout, writes zeros, and writes a new selector without a kick. These show whether a design disarms on a zero write, restarts on it, or takes up a selector early. It checks the reset pulse length and watches for a second pulse after it. It also runs the external reset filter with one sample fewer than the limit and with exactly the limit in both modes. A filter with an off-by-one count, or one that ignores stop mode, fails one of these cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KICK_BIT = 0;
  localparam int SEL_LSB  = 1;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    TO_X1  = 2'd0,
    TO_X4  = 2'd1,
    TO_X16 = 2'd2,
    TO_X64 = 2'd3
  } wdt_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (PRE_LOG2 == 0) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PRE_LOG2-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    pre_q <= '0;
        else if (clr_i) pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
      end
      assign tick_o = &pre_q;

      // R4: ticks never come on consecutive clocks when dividing
      a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int PRE_LOG2  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       block_i,
  input  logic       kick_i,
  input  wdt_sel_e   sel_i,
  input  logic       tick_i,
  output logic       armed_o,
  output logic       restart_o,
  output logic       expire_o
);
  localparam int LIM_BASE = BASE_LOG2 - PRE_LOG2;
  localparam int CW       = LIM_BASE + 7;

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  wdt_sel_e      sel_q;
  logic [CW-1:0] lim;

  assign lim       = {{(CW-1){1'b0}}, 1'b1} << (LIM_BASE + 2 * int'(sel_q));
  assign restart_o = kick_i && !block_i && !clr_i;
  assign expire_o  = armed_q && tick_i && (cnt_q == lim - 1'b1);
  assign armed_o   = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sel_q   <= TO_X1;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sel_q   <= TO_X1;
    end else if (restart_o) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      sel_q   <= sel_i;
    end else if (expire_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  a_r1_arm_on_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> armed_q);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !clr_i && !expire_o |=> armed_q);
  a_r9_clr_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !armed_q);
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_q < lim);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          active_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
    end else if (!active_q && expire_i) begin
      active_q <= 1'b1;
      pcnt_q   <= PW'(PULSE_LEN);
    end else if (active_q) begin
      pcnt_q <= pcnt_q - 1'b1;
      if (pcnt_q == PW'(1)) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

  a_r6_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !active_q |=> active_q);
  a_r6_pulse_needs_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(expire_i));
endmodule

// File: rtl/wdt_rst_filter.sv
module wdt_rst_filter #(
  parameter int MIN_NORM = 5,
  parameter int MIN_STOP = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic stop_i,
  output logic hw_rst_o
);
  localparam int MAXC  = (MIN_STOP > MIN_NORM) ? MIN_STOP : MIN_NORM;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, need;
  logic             hw_q;

  assign need  = stop_i ? CNT_W'(MIN_STOP) : CNT_W'(MIN_NORM);
  assign cnt_d = (cnt_q == CNT_W'(MAXC)) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hw_q  <= 1'b0;
    end else if (ext_rst_ni) begin
      cnt_q <= '0;
      hw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hw_q  <= (cnt_d >= need);
    end
  end

  assign hw_rst_o = hw_q;

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_ni |=> !hw_q);
  a_r8_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hw_q) |-> $past(!ext_rst_ni));
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int PRE_LOG2  = 4,
  parameter int PULSE_LEN = 16,
  parameter int MIN_NORM  = 5,
  parameter int MIN_STOP  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       ext_rst_ni,
  input  logic       stop_mode_i,
  output logic       rst_req_no,
  output logic       sys_rst_no
);
  logic     hw_rst, kick, tick, armed, restart, expire, pulse_on;
  wdt_sel_e sel;

  assign kick = wr_en_i && wr_data_i[KICK_BIT];
  assign sel  = wdt_sel_e'(wr_data_i[SEL_LSB +: SEL_W]);

  wdt_rst_filter #(.MIN_NORM(MIN_NORM), .MIN_STOP(MIN_STOP)) i_filter (
    .clk_i, .rst_ni, .ext_rst_ni, .stop_i(stop_mode_i), .hw_rst_o(hw_rst));

  wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) i_pre (
    .clk_i, .rst_ni, .clr_i(restart || hw_rst), .tick_o(tick));

  wdt_counter #(.BASE_LOG2(BASE_LOG2), .PRE_LOG2(PRE_LOG2)) i_cnt (
    .clk_i, .rst_ni, .clr_i(hw_rst), .block_i(pulse_on), .kick_i(kick),
    .sel_i(sel), .tick_i(tick), .armed_o(armed), .restart_o(restart),
    .expire_o(expire));

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk_i, .rst_ni, .expire_i(expire), .active_o(pulse_on));

  assign rst_req_no = !pulse_on;
  assign sys_rst_no = !hw_rst;

  a_r7_disarmed_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_on |-> !armed);
endmodule

// File: tb/test_wdt_sticky.sv
module test_wdt_sticky;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 6;
  localparam int PRE  = 2;
  localparam int PLEN = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_n = 1'b1, stop = 1'b0;
  logic [7:0] wr_data = '0;
  logic rst_req_n, sys_rst_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_sticky #(.BASE_LOG2(BASE), .PRE_LOG2(PRE), .PULSE_LEN(PLEN)) i_wdt_sticky (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ext_rst_ni(ext_n), .stop_mode_i(stop), .rst_req_no(rst_req_n),
    .sys_rst_no(sys_rst_n));

  function automatic int tmo(int sel);
    return 1 << (BASE + 2 * sel);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic k, int sel);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {5'b0, 2'(sel), k};
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  // from just after the write edge: low exactly t clocks later, for PLEN clocks
  task automatic expect_expiry(string req, int t);
    repeat (t - 1) @(negedge clk);
    chk(req, rst_req_n, 1'b1);
    @(negedge clk);
    chk(req, rst_req_n, 1'b0);
    repeat (PLEN - 1) @(negedge clk);
    chk({req, " R6 len"}, rst_req_n, 1'b0);
    @(negedge clk);
    chk({req, " R6 end"}, rst_req_n, 1'b1);
  endtask

  task automatic expect_quiet(string req, int n);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (!rst_req_n) lows++;
    end
    n_run++;
    if (lows != 0) begin
      n_fail++;
      $display("FAIL %s: %0d low clocks, expected 0", req, lows);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 rst_req", rst_req_n, 1'b1);
    chk("R10 sys_rst", sys_rst_n, 1'b1);
    expect_quiet("R10 disarmed", tmo(0) + 8);
  endtask

  task automatic t_timeouts;
    for (int s = 0; s < 4; s++) begin
      wr(1'b1, s);
      expect_expiry($sformatf("R1 R4 sel%0d", s), tmo(s));
    end
  endtask

  task automatic t_kick;
    wr(1'b1, 1);
    repeat (tmo(1) / 2 - 1) @(negedge clk);
    wr(1'b1, 1);
    expect_expiry("R2 restart", tmo(1));
  endtask

  task automatic t_zero_write;
    wr(1'b0, 0);
    expect_quiet("R3 no arm", tmo(0) + 8);
    wr(1'b1, 0);
    repeat (tmo(0) / 2 - 1) @(negedge clk);
    wr(1'b0, 3);
    // armed edge was tmo/2+1 clocks ago; expiry keeps the original schedule
    expect_expiry("R3 R5 no restart", tmo(0) / 2 - 1);
  endtask

  task automatic t_sel_change;
    wr(1'b1, 0);
    repeat (8) @(negedge clk);
    wr(1'b1, 2);
    expect_expiry("R5 new sel", tmo(2));
  endtask

  task automatic t_pulse_ignore;
    wr(1'b1, 0);
    repeat (tmo(0)) @(negedge clk);
    chk("R6 low", rst_req_n, 1'b0);
    wr(1'b1, 0);
    repeat (PLEN) @(negedge clk);
    chk("R6 over", rst_req_n, 1'b1);
    expect_quiet("R6 R7 no rearm", tmo(0) + 16);
  endtask

  task automatic filt(string req, logic st, int len, logic exp_n);
    @(negedge clk);
    stop = st;
    ext_n = 1'b0;
    repeat (len) @(negedge clk);
    chk(req, sys_rst_n, exp_n);
    ext_n = 1'b1;
    @(negedge clk);
    chk({req, " release"}, sys_rst_n, 1'b1);
    stop = 1'b0;
  endtask

  task automatic t_filter;
    filt("R8 norm 4", 1'b0, 4, 1'b1);
    filt("R8 norm 5", 1'b0, 5, 1'b0);
    filt("R8 stop 9", 1'b1, 9, 1'b1);
    filt("R8 stop 10", 1'b1, 10, 1'b0);
  endtask

  task automatic t_hw_disarm;
    wr(1'b1, 0);
    repeat (10) @(negedge clk);
    filt("R9 accept", 1'b0, 5, 1'b0);
    expect_quiet("R9 disarmed", tmo(0) + 16);
    filt("R9 short", 1'b0, 3, 1'b1);
    wr(1'b1, 0);
    expect_expiry("R9 rearm", tmo(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timeouts();
    t_kick();
    t_zero_write();
    t_sel_change();
    t_pulse_ignore();
    t_filter();
    t_hw_disarm();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule